// File: doc/BRIEF.md
# Multi-Mode Host Bus Front End

This block sits between an external host and the register side of a display controller. The host reaches it over one of three bus forms, chosen by static strap inputs. The first parallel form uses separate active-low read and write strobes. The second uses one enable strobe plus a read/write level. The third is a clocked serial line. Whatever the bus form, each finished host access becomes one internal single-cycle event: a load of the index register, a data write aimed at the current index, or a read request whose return byte goes back out on the parallel data pins.

All host pins are asynchronous to the system clock. They pass through a two-stage synchronizer, and all decoding runs in the system clock domain. The parallel path is a four-state machine: `P_IDLE`, `P_WRITE` (a write strobe is active), `P_READ` (a legal read is active and the data pins are driven) and `P_BLOCK` (a read with the select line low is absorbed and produces nothing). From `P_IDLE`, an active write goes to `P_WRITE`. An active read goes to `P_READ` when the select line is high, and to `P_BLOCK` when it is low. `P_WRITE` returns to `P_IDLE` when the write completes, and emits the event. `P_READ` and `P_BLOCK` return to `P_IDLE` when the read strobe is released. Every state returns to `P_IDLE` at once if chip select drops. The serial path is a bit counter with a shift register.

Top module: `hostbus_front`

## Requirements
- R1: After reset `idx_q` is 0, and `idx_load`, `wr_pulse`, `rd_req` and `pd_oe` are all 0.
- R2: In separate-strobe style (`par_mode`=1, `strobe_style`=0), a low-then-high pulse on `host_dir` while `host_stb` is high and `addr_sel`=0 loads `pd_in` into `idx_q`. `idx_load` is high for exactly one cycle, three clock edges after the rising edge of `host_dir`.
- R3: The same write with `addr_sel`=1 gives one `wr_pulse` cycle, three edges after the rising strobe, with `wr_byte`=`pd_in` and `wr_idx`=`idx_q`. `idx_q` does not change. At most one of `idx_load`, `wr_pulse` and `rd_req` is high in any cycle.
- R4: In separate-strobe style, `host_stb` going low while `host_dir` is high and `addr_sel`=1 gives one `rd_req` cycle with `rd_idx`=`idx_q`, three edges after the falling strobe. From that cycle, `pd_oe`=1 and `pd_out`=`rd_byte`. This lasts until three edges after `host_stb` rises.
- R5: A read cycle with `addr_sel`=0, in either parallel style, gives no `rd_req`, and `pd_oe` stays 0.
- R6: In enable style (`strobe_style`=1), a write with `host_dir`=0 completes on the falling edge of `host_stb`. Three edges later it gives `idx_load` (when `addr_sel`=0) or `wr_pulse` (when `addr_sel`=1), with the same data rules as R2 and R3.
- R7: In enable style, `host_stb` high with `host_dir`=1 and `addr_sel`=1 is a read, timed as in R4 from the rise and fall of `host_stb`.
- R8: An access counts only while `sel_n`=0 and `sel_p`=1. Strobes given with either select inactive produce no event, and `pd_oe` stays 0.
- R9: In serial mode (`par_mode`=0), 8 rising edges of `ser_clk` shift `ser_din` in with the most significant bit first. `addr_sel` is sampled at the eighth edge: 0 gives an index load and 1 gives a data write. The event appears three clock edges after the eighth rising edge.
- R10: In serial mode, deasserting chip select part way through a byte discards the bits already taken. The next byte starts from bit 7.
- R11: In serial mode `pd_oe` stays 0, and activity on `host_stb` and `host_dir` produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_mode | input | 1 | Strap: 1 parallel bus, 0 serial |
| strobe_style | input | 1 | Strap: 1 enable plus read/write level, 0 separate read and write strobes |
| sel_n | input | 1 | Active-low chip select |
| sel_p | input | 1 | Active-high chip select |
| addr_sel | input | 1 | 0 index register access, 1 indexed data access |
| host_stb | input | 1 | Read strobe (active low) or enable (active high) |
| host_dir | input | 1 | Write strobe (active low) or read/write level (1 = read) |
| pd_in | input | 8 | Parallel data from host |
| pd_out | output | 8 | Parallel data to host |
| pd_oe | output | 1 | Drive enable for the parallel data pins |
| ser_clk | input | 1 | Serial shift clock |
| ser_din | input | 1 | Serial data input |
| idx_q | output | 8 | Current index register |
| idx_load | output | 1 | One-cycle pulse when the index register is loaded |
| wr_pulse | output | 1 | One-cycle data write strobe |
| wr_byte | output | 8 | Data byte of the write |
| wr_idx | output | 8 | Target index of the write |
| rd_req | output | 1 | One-cycle read request |
| rd_idx | output | 8 | Target index of the read |
| rd_byte | input | 8 | Return byte for the read, valid combinationally from `rd_idx` |

## Verification
The assertions assume that the strap inputs change only while chip select is inactive and the bus is idle. They also assume that `pd_in` and `addr_sel` stay steady from before a strobe starts until several clock cycles after it ends, and that every strobe level lasts at least two clock cycles, so the synchronized copies never skip an edge. The stimulus changes modes only inside a deselected window with the strobes parked at their idle levels. It holds data and select around every strobe edge, and keeps each serial clock phase at least two system cycles long. `rd_byte` is supplied as a fixed function of `rd_idx`, which gives a stable return byte for as long as a read lasts.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
    localparam int unsigned HBF_BYTE_W = 8;

    typedef enum logic [1:0] {
        P_IDLE,
        P_WRITE,
        P_READ,
        P_BLOCK
    } par_state_e;
endpackage

// File: rtl/hbf_sync.sv
module hbf_sync #(
    parameter int unsigned         W       = 1,
    parameter int unsigned         STAGES  = 2,
    parameter logic [W-1:0]        RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= RST_VAL;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbf_par_fsm.sv
module hbf_par_fsm
    import hbf_pkg::*;
#(
    parameter int unsigned DW = HBF_BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          enable_style,
    input  logic          sel_s,
    input  logic          rsel_s,
    input  logic          stb_s,
    input  logic          dir_s,
    input  logic [DW-1:0] data_s,
    output logic          ev_valid,
    output logic          ev_index,
    output logic [DW-1:0] ev_data,
    output logic          rd_go,
    output logic          oe
);
    par_state_e state, state_nx;
    logic live, wr_act, rd_act, wr_done;

    always_comb begin
        live    = enable & sel_s;
        wr_act  = stb_s & ~dir_s;
        rd_act  = enable_style ? (stb_s & dir_s) : (~stb_s & dir_s);
        wr_done = enable_style ? ~stb_s : dir_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= P_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            P_IDLE: begin
                if (live && wr_act)      state_nx = P_WRITE;
                else if (live && rd_act) state_nx = rsel_s ? P_READ : P_BLOCK;
            end
            P_WRITE: begin
                if (!live || wr_done)    state_nx = P_IDLE;
            end
            P_READ, P_BLOCK: begin
                if (!live || !rd_act)    state_nx = P_IDLE;
            end
            default:                     state_nx = P_IDLE;
        endcase
    end

    always_comb begin
        ev_valid = 1'b0;
        rd_go    = 1'b0;
        oe       = 1'b0;
        ev_index = ~rsel_s;
        ev_data  = data_s;
        unique case (state)
            P_IDLE:  rd_go    = live & ~wr_act & rd_act & rsel_s;
            P_WRITE: ev_valid = live & wr_done;
            P_READ:  oe       = 1'b1;
            P_BLOCK: oe       = 1'b0;
            default: oe       = 1'b0;
        endcase
    end

    // R4: the data pins are only ever turned on by a read that was accepted
    assert_oe_from_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(rd_go));

    // R5: a read absorbed with the select line low never drives the pins next cycle
    assert_block_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == P_BLOCK) |=> (state != P_READ));
endmodule

// File: rtl/hbf_ser_rx.sv
module hbf_ser_rx
    import hbf_pkg::*;
#(
    parameter int unsigned DW = HBF_BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          sel_s,
    input  logic          rsel_s,
    input  logic          sclk_s,
    input  logic          sdi_s,
    output logic          ev_valid,
    output logic          ev_index,
    output logic [DW-1:0] ev_data
);
    localparam int unsigned CW   = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    logic [CW-1:0] cnt;
    logic [DW-2:0] sh;
    logic          sclk_prev;
    logic          live, rise;

    assign live = enable & sel_s;
    assign rise = sclk_s & ~sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            cnt       <= '0;
            sh        <= '0;
        end else begin
            sclk_prev <= sclk_s;
            if (!live) begin
                cnt <= '0;
            end else if (rise) begin
                sh  <= {sh[DW-3:0], sdi_s};
                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end
        end
    end

    assign ev_valid = live & rise & (cnt == LAST);
    assign ev_index = ~rsel_s;
    assign ev_data  = {sh, sdi_s};

    // R10: losing chip select clears any partly received byte
    assert_partial_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> (cnt == '0));
endmodule

// File: rtl/hostbus_front.sv
module hostbus_front
    import hbf_pkg::*;
#(
    parameter int unsigned DW          = HBF_BYTE_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          par_mode,
    input  logic          strobe_style,
    input  logic          sel_n,
    input  logic          sel_p,
    input  logic          addr_sel,
    input  logic          host_stb,
    input  logic          host_dir,
    input  logic [DW-1:0] pd_in,
    output logic [DW-1:0] pd_out,
    output logic          pd_oe,
    input  logic          ser_clk,
    input  logic          ser_din,
    output logic [DW-1:0] idx_q,
    output logic          idx_load,
    output logic          wr_pulse,
    output logic [DW-1:0] wr_byte,
    output logic [DW-1:0] wr_idx,
    output logic          rd_req,
    output logic [DW-1:0] rd_idx,
    input  logic [DW-1:0] rd_byte
);
    localparam int unsigned SW = DW + 7;
    localparam logic [SW-1:0] SYNC_RST = {1'b1, {(SW-1){1'b0}}};

    logic [SW-1:0] raw_bus, syn_bus;
    logic          seln_s, selp_s, rsel_s, stb_s, dir_s, sclk_s, sdi_s;
    logic [DW-1:0] data_s;
    logic          sel_s;

    assign raw_bus = {sel_n, sel_p, addr_sel, host_stb, host_dir, ser_clk, ser_din, pd_in};

    hbf_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(syn_bus)
    );

    assign {seln_s, selp_s, rsel_s, stb_s, dir_s, sclk_s, sdi_s, data_s} = syn_bus;
    assign sel_s = ~seln_s & selp_s;

    logic          p_valid, p_index, p_rd_go, p_oe;
    logic [DW-1:0] p_data;
    logic          s_valid, s_index;
    logic [DW-1:0] s_data;

    hbf_par_fsm #(.DW(DW)) u_par (
        .clk(clk), .rst_n(rst_n), .enable(par_mode), .enable_style(strobe_style),
        .sel_s(sel_s), .rsel_s(rsel_s), .stb_s(stb_s), .dir_s(dir_s), .data_s(data_s),
        .ev_valid(p_valid), .ev_index(p_index), .ev_data(p_data),
        .rd_go(p_rd_go), .oe(p_oe)
    );

    hbf_ser_rx #(.DW(DW)) u_ser (
        .clk(clk), .rst_n(rst_n), .enable(~par_mode), .sel_s(sel_s), .rsel_s(rsel_s),
        .sclk_s(sclk_s), .sdi_s(sdi_s),
        .ev_valid(s_valid), .ev_index(s_index), .ev_data(s_data)
    );

    logic          ev_valid, ev_index;
    logic [DW-1:0] ev_data;

    always_comb begin
        if (par_mode) begin
            ev_valid = p_valid;
            ev_index = p_index;
            ev_data  = p_data;
        end else begin
            ev_valid = s_valid;
            ev_index = s_index;
            ev_data  = s_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            idx_load <= 1'b0;
            wr_pulse <= 1'b0;
            wr_byte  <= '0;
            wr_idx   <= '0;
            rd_req   <= 1'b0;
        end else begin
            idx_load <= ev_valid & ev_index;
            wr_pulse <= ev_valid & ~ev_index;
            rd_req   <= p_rd_go;
            if (ev_valid && ev_index) idx_q <= ev_data;
            if (ev_valid && !ev_index) begin
                wr_byte <= ev_data;
                wr_idx  <= idx_q;
            end
        end
    end

    assign rd_idx = idx_q;
    assign pd_oe  = p_oe;
    assign pd_out = p_oe ? rd_byte : '0;

    // R3: never more than one internal event in a cycle
    assert_single_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({idx_load, wr_pulse, rd_req}));

    // R3: data writes leave the index untouched
    assert_idx_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> $stable(idx_q));

    // R4: a read request comes together with the pins being driven
    assert_read_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> pd_oe);

    // R8: every event was raised while both chip selects were active
    assert_event_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_load || wr_pulse || rd_req) |-> $past(sel_s));

    // R11: the pins are only driven in parallel mode
    assert_oe_parallel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pd_oe |-> par_mode);
endmodule

// File: tb/sim_hostbus_front.sv
module sim_hostbus_front;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_mode = 1'b1, strobe_style = 1'b0;
    logic       sel_n = 1'b1, sel_p = 1'b1, addr_sel = 1'b0;
    logic       host_stb = 1'b1, host_dir = 1'b1;
    logic [7:0] pd_in = 8'h00;
    logic       ser_clk = 1'b0, ser_din = 1'b0;
    logic [7:0] pd_out, idx_q, wr_byte, wr_idx, rd_idx, rd_byte;
    logic       pd_oe, idx_load, wr_pulse, rd_req;

    always #10 clk = ~clk;

    assign rd_byte = rd_idx ^ 8'h5A;

    hostbus_front u0 (
        .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .strobe_style(strobe_style),
        .sel_n(sel_n), .sel_p(sel_p), .addr_sel(addr_sel), .host_stb(host_stb),
        .host_dir(host_dir), .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
        .ser_clk(ser_clk), .ser_din(ser_din), .idx_q(idx_q), .idx_load(idx_load),
        .wr_pulse(wr_pulse), .wr_byte(wr_byte), .wr_idx(wr_idx), .rd_req(rd_req),
        .rd_idx(rd_idx), .rd_byte(rd_byte)
    );

    int    cyc = 0, checks = 0, fails = 0;
    string cur_req = "R1";
    bit    running = 1'b0;

    bit         exp_wr[int], exp_ld[int], exp_rr[int], exp_on[int], exp_off[int];
    logic [7:0] exp_wrb[int], exp_wri[int], exp_ldv[int];
    logic [7:0] p_idx = 8'h00, m_idx = 8'h00;
    bit         m_oe = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", cur_req, what, act, exp, cyc);
        end
    endtask

    always @(posedge clk) if (cyc > 40000) begin
        checks++; fails++;
        $display("FAIL %s watchdog expired", cur_req);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // per-cycle comparison against the behavioural expectation tables
    always @(negedge clk) if (running) begin
        automatic int k = cyc;
        automatic bit e_wr = exp_wr.exists(k);
        automatic bit e_ld = exp_ld.exists(k);
        automatic bit e_rr = exp_rr.exists(k);
        chk(wr_pulse == e_wr, "wr_pulse", {7'd0, wr_pulse}, {7'd0, e_wr});
        if (e_wr) begin
            chk(wr_byte == exp_wrb[k], "wr_byte", wr_byte, exp_wrb[k]);
            chk(wr_idx == exp_wri[k], "wr_idx", wr_idx, exp_wri[k]);
        end
        chk(idx_load == e_ld, "idx_load", {7'd0, idx_load}, {7'd0, e_ld});
        if (e_ld) m_idx = exp_ldv[k];
        chk(idx_q == m_idx, "idx_q", idx_q, m_idx);
        chk(rd_req == e_rr, "rd_req", {7'd0, rd_req}, {7'd0, e_rr});
        if (e_rr) chk(rd_idx == m_idx, "rd_idx", rd_idx, m_idx);
        if (exp_on.exists(k))  m_oe = 1'b1;
        if (exp_off.exists(k)) m_oe = 1'b0;
        chk(pd_oe == m_oe, "pd_oe", {7'd0, pd_oe}, {7'd0, m_oe});
        if (m_oe) chk(pd_out == (m_idx ^ 8'h5A), "pd_out", pd_out, m_idx ^ 8'h5A);
    end

    function automatic bit en_par();
        return !sel_n && sel_p && par_mode;
    endfunction

    function automatic bit en_ser();
        return !sel_n && sel_p && !par_mode;
    endfunction

    task automatic plan_write(input int c, input logic rs, input logic [7:0] d);
        if (rs) begin
            exp_wr[c] = 1'b1; exp_wrb[c] = d; exp_wri[c] = p_idx;
        end else begin
            exp_ld[c] = 1'b1; exp_ldv[c] = d; p_idx = d;
        end
    endtask

    task automatic set_mode(input logic par, input logic style);
        @(negedge clk);
        sel_n = 1'b1; host_dir = 1'b1; ser_clk = 1'b0;
        host_stb = (par && !style) ? 1'b1 : 1'b0;
        repeat (4) @(negedge clk);
        par_mode = par; strobe_style = style;
        repeat (4) @(negedge clk);
        sel_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic sep_write(input logic rs, input logic [7:0] d);
        @(negedge clk); addr_sel = rs; pd_in = d;
        @(negedge clk); host_dir = 1'b0;
        repeat (3) @(negedge clk);
        host_dir = 1'b1;
        if (en_par()) plan_write(cyc + 3, rs, d);
        repeat (5) @(negedge clk);
    endtask

    task automatic sep_read(input logic rs);
        @(negedge clk); addr_sel = rs;
        @(negedge clk); host_stb = 1'b0;
        if (en_par() && rs) begin exp_rr[cyc + 3] = 1'b1; exp_on[cyc + 3] = 1'b1; end
        repeat (5) @(negedge clk);
        host_stb = 1'b1;
        if (en_par() && rs) exp_off[cyc + 3] = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic en_write(input logic rs, input logic [7:0] d);
        @(negedge clk); addr_sel = rs; pd_in = d; host_dir = 1'b0;
        @(negedge clk); host_stb = 1'b1;
        repeat (3) @(negedge clk);
        host_stb = 1'b0;
        if (en_par()) plan_write(cyc + 3, rs, d);
        repeat (3) @(negedge clk);
        host_dir = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic en_read(input logic rs);
        @(negedge clk); addr_sel = rs; host_dir = 1'b1;
        @(negedge clk); host_stb = 1'b1;
        if (en_par() && rs) begin exp_rr[cyc + 3] = 1'b1; exp_on[cyc + 3] = 1'b1; end
        repeat (5) @(negedge clk);
        host_stb = 1'b0;
        if (en_par() && rs) exp_off[cyc + 3] = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic ser_send(input logic rs, input logic [7:0] d, input int nbits);
        int last = 0;
        @(negedge clk); addr_sel = rs;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk); ser_din = d[7 - i];
            @(negedge clk); ser_clk = 1'b1; last = cyc;
            repeat (2) @(negedge clk);
            ser_clk = 1'b0;
            @(negedge clk);
        end
        if (nbits == 8 && en_ser()) plan_write(last + 3, rs, d);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk(idx_q == 8'h00, "reset idx_q", idx_q, 8'h00);
        chk({idx_load, wr_pulse, rd_req, pd_oe} == 4'b0000, "reset pulses",
            {4'd0, idx_load, wr_pulse, rd_req, pd_oe}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        running = 1'b1;
        set_mode(1'b1, 1'b0);

        cur_req = "R2"; sep_write(1'b0, 8'h3C);
        cur_req = "R3"; sep_write(1'b1, 8'hA5); sep_write(1'b1, 8'h00);
        cur_req = "R4"; sep_read(1'b1);
        cur_req = "R5"; sep_read(1'b0);

        cur_req = "R8";
        @(negedge clk); sel_p = 1'b0;
        sep_write(1'b0, 8'hF0); sep_read(1'b1);
        @(negedge clk); sel_p = 1'b1; sel_n = 1'b1;
        sep_write(1'b1, 8'h11); sep_read(1'b1);
        @(negedge clk); sel_n = 1'b0;
        repeat (4) @(negedge clk);
        sep_write(1'b0, 8'h42);

        set_mode(1'b1, 1'b1);
        cur_req = "R6"; en_write(1'b0, 8'h81); en_write(1'b1, 8'h7E);
        cur_req = "R7"; en_read(1'b1);
        cur_req = "R5"; en_read(1'b0);

        set_mode(1'b0, 1'b0);
        cur_req = "R9"; ser_send(1'b0, 8'hC3, 8); ser_send(1'b1, 8'h96, 8);
        cur_req = "R10";
        ser_send(1'b1, 8'hFF, 5);
        @(negedge clk); sel_n = 1'b1;
        repeat (4) @(negedge clk);
        sel_n = 1'b0;
        repeat (4) @(negedge clk);
        ser_send(1'b1, 8'h5B, 8);
        cur_req = "R11";
        @(negedge clk); host_stb = 1'b1;
        sep_write(1'b1, 8'hEE); sep_read(1'b1);

        repeat (8) @(negedge clk);
        running = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule